// File: doc/BRIEF.md
# Escalating Watchdog Timer

This block guards one processor core against lockup. Software programs a 16-bit length and an escalation mode, then must keep writing a one to a separate keep-alive (poke) input. If the keep-alive stops, each full period that passes without one moves the watchdog one step further along a fixed ladder. The first missed period raises an interrupt. The second raises a non-maskable interrupt. The third issues a one-cycle chip soft-reset request.

The period comes from a down-counter whose upper bits are loaded from the length and whose lower `FRAC_W` bits are loaded as zero. A free-running prescaler divides the clock so that the down-counter moves once every `2^PRESC_W` cycles. With the default parameters (16-bit length, 8 low bits, divide by 256), the longest period is close to 2^32 clocks.

The current stage can be read back at any time. A sticky flag records that the NMI step was reached, and it keeps that record after the reset pulse.

Top module: `wdt_escalator`

## Requirements
- R1: After reset the watchdog is disabled (mode 0). `stage_o` is 0, and `irq_o`, `nmi_o`, `sreset_o` and `nmi_seen_o` are all low.
- R2: A period lasts max(L·2^FRAC_W, 1) counter steps, where L is the programmed length. One step happens every 2^PRESC_W clocks. When the counter expires it reloads from the stored length, and the next period starts at once.
- R3: The first expiry after a clean start sets `stage_o` to 1 (interrupt stage) and raises `irq_o`.
- R4: The next expiry without a poke sets `stage_o` to 2 (NMI stage) and raises `nmi_o`, while `irq_o` stays high. It also sets `nmi_seen_o`.
- R5: In mode 3, the expiry after the NMI stage drives `sreset_o` high for exactly one clock. At the same time `stage_o` returns to 0, `irq_o` and `nmi_o` fall, and `nmi_seen_o` stays high. Counting then carries on with the same configuration.
- R6: Mode 1 stops escalation at stage 1, and mode 2 stops it at stage 2. Later expiries only reload the counter and never pulse `sreset_o`.
- R7: Mode 0 disables the block. The counter stops, no stage is reached, and all outputs stay low. Writing mode 0 while a stage is active drops every output on the next clock.
- R8: A poke (`poke_we` with `poke_data`=1) does four things: it reloads the counter, restarts the prescaler, returns `stage_o` to 0, and clears `irq_o`, `nmi_o` and `nmi_seen_o`. A write with `poke_data`=0 is ignored.
- R9: When a poke and an expiry fall in the same clock, the poke wins. The stage stays at 0, and the next expiry comes one full period after the poke.
- R10: A configuration write stores the new length and mode and clears the stage. It also reloads the counter and restarts the prescaler, so the new period is measured from the write and not from any earlier one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_len | input | LEN_W | Period length (upper counter bits) |
| cfg_mode | input | 2 | 0 off, 1 interrupt only, 2 up to NMI, 3 up to soft reset |
| poke_we | input | 1 | Keep-alive write strobe |
| poke_data | input | 1 | Keep-alive data; only 1 acts |
| stage_o | output | 2 | 0 idle, 1 interrupt, 2 NMI |
| nmi_seen_o | output | 1 | Sticky: NMI stage reached since last poke or write |
| irq_o | output | 1 | Interrupt request |
| nmi_o | output | 1 | Non-maskable interrupt request |
| sreset_o | output | 1 | One-cycle soft-reset request |

## Verification
The hardest case to reach is a poke that lands in exactly the clock where the counter expires. The bench works out that edge from the configuration write and the prescaler division, then drives the poke so it is sampled at that edge. It also runs a complete three-stage escalation through the reset pulse and past it into the next period. This shows that the sticky NMI flag survives the reset pulse and that counting resumes. The bench uses a reduced prescaler and reduced low-bit width so that several whole periods fit in a short run.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        STG_IDLE = 2'd0,
        STG_IRQ  = 2'd1,
        STG_NMI  = 2'd2
    } stage_e;

    localparam logic [1:0] MODE_OFF = 2'd0;
    localparam logic [1:0] MODE_IRQ = 2'd1;
    localparam logic [1:0] MODE_NMI = 2'd2;
    localparam logic [1:0] MODE_ALL = 2'd3;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PRESC_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    generate
        if (PRESC_W == 0) begin : g_nodiv
            assign tick = run && !restart;
        end else begin : g_div
            typedef struct packed {
                logic [PRESC_W-1:0] cnt;
            } presc_t;

            presc_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (restart) begin
                    st_d.cnt = '0;
                end else if (run) begin
                    st_d.cnt = st_q.cnt + PRESC_W'(1);
                end
            end

            assign tick = run && !restart && (st_q.cnt == '1);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int LEN_W  = 16,
    parameter int FRAC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tick,
    input  logic [LEN_W-1:0] len,
    output logic             expire
);
    localparam int CNT_W = LEN_W + FRAC_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t st_d, st_q;
    logic [CNT_W-1:0] reload_val;

    assign reload_val = CNT_W'(len) << FRAC_W;

    always_comb begin
        st_d   = st_q;
        expire = tick && !load && (st_q.cnt < CNT_W'(2));
        if (load || expire) begin
            st_d.cnt = reload_val;
        end else if (tick) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wdt_stage_fsm.sv
module wdt_stage_fsm
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       expire,
    input  logic [1:0] mode,
    output logic [1:0] stage,
    output logic       irq,
    output logic       nmi,
    output logic       sreset,
    output logic       nmi_seen
);
    typedef struct packed {
        stage_e stage;
        logic   irq;
        logic   nmi;
        logic   sreset;
        logic   seen;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.sreset = 1'b0;
        if (clear) begin
            st_d.stage = STG_IDLE;
            st_d.irq   = 1'b0;
            st_d.nmi   = 1'b0;
            st_d.seen  = 1'b0;
        end else if (expire) begin
            case (st_q.stage)
                STG_IDLE: begin
                    if (mode >= MODE_IRQ) begin
                        st_d.stage = STG_IRQ;
                        st_d.irq   = 1'b1;
                    end
                end
                STG_IRQ: begin
                    if (mode >= MODE_NMI) begin
                        st_d.stage = STG_NMI;
                        st_d.nmi   = 1'b1;
                        st_d.seen  = 1'b1;
                    end
                end
                STG_NMI: begin
                    if (mode == MODE_ALL) begin
                        st_d.stage  = STG_IDLE;
                        st_d.irq    = 1'b0;
                        st_d.nmi    = 1'b0;
                        st_d.sreset = 1'b1;
                    end
                end
                default: begin
                    st_d.stage = STG_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stage  <= STG_IDLE;
            st_q.irq    <= 1'b0;
            st_q.nmi    <= 1'b0;
            st_q.sreset <= 1'b0;
            st_q.seen   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stage    = st_q.stage;
    assign irq      = st_q.irq;
    assign nmi      = st_q.nmi;
    assign sreset   = st_q.sreset;
    assign nmi_seen = st_q.seen;
endmodule

// File: rtl/wdt_escalator.sv
module wdt_escalator
    import wdt_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int FRAC_W  = 8,
    parameter int PRESC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [1:0]       cfg_mode,
    input  logic             poke_we,
    input  logic             poke_data,
    output logic [1:0]       stage_o,
    output logic             nmi_seen_o,
    output logic             irq_o,
    output logic             nmi_o,
    output logic             sreset_o
);
    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [1:0]       mode;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic             poke_fire;
    logic             restart;
    logic             run;
    logic             tick;
    logic             expire;
    logic [LEN_W-1:0] load_len;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d.len  = cfg_len;
            cfg_d.mode = cfg_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign poke_fire = poke_we && poke_data;
    assign restart   = cfg_we || poke_fire;
    assign run       = (cfg_q.mode != MODE_OFF);
    assign load_len  = cfg_we ? cfg_len : cfg_q.len;

    wdt_prescaler #(
        .PRESC_W(PRESC_W)
    ) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .run    (run),
        .tick   (tick)
    );

    wdt_counter #(
        .LEN_W (LEN_W),
        .FRAC_W(FRAC_W)
    ) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (restart),
        .tick  (tick),
        .len   (load_len),
        .expire(expire)
    );

    wdt_stage_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (restart),
        .expire  (expire),
        .mode    (cfg_q.mode),
        .stage   (stage_o),
        .irq     (irq_o),
        .nmi     (nmi_o),
        .sreset  (sreset_o),
        .nmi_seen(nmi_seen_o)
    );
endmodule

// File: rtl/wdt_escalator_chk.sv
module wdt_escalator_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic       poke_we,
    input logic       poke_data,
    input logic [1:0] stage_o,
    input logic       nmi_seen_o,
    input logic       irq_o,
    input logic       nmi_o,
    input logic       sreset_o
);
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sreset_o |=> !sreset_o);

    a_r5_from_nmi: assert property (@(posedge clk) disable iff (!rst_n)
        sreset_o |-> ($past(stage_o) == 2'd2 && stage_o == 2'd0 && nmi_seen_o));

    a_r4_nmi_flags: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |-> (irq_o && nmi_seen_o));

    a_r3_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_o == 2'd0) |=> (stage_o != 2'd2));

    a_r8_poke_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (poke_we && poke_data) |=> (stage_o == 2'd0 && !irq_o && !nmi_o && !nmi_seen_o));

    a_r10_cfg_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (stage_o == 2'd0 && !irq_o && !nmi_o && !sreset_o));
endmodule

bind wdt_escalator wdt_escalator_chk u_chk (.*);

// File: tb/wdt_escalator_test.sv
`timescale 1ns/1ps
module wdt_escalator_test;
    localparam int LW = 16;
    localparam int FW = 4;
    localparam int PW = 2;
    localparam int STEP = 1 << PW;
    localparam int T1 = 16 * STEP;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [LW-1:0] cfg_len = '0;
    logic [1:0]    cfg_mode = 2'd0;
    logic          poke_we = 1'b0;
    logic          poke_data = 1'b0;
    logic [1:0]    stage_o;
    logic          nmi_seen_o, irq_o, nmi_o, sreset_o;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    typedef struct {
        int        c;
        int        st;
        bit        irq;
        bit        nmi;
        bit        srst;
        bit        seen;
        string     tag;
    } exp_t;

    exp_t sb[$];

    wdt_escalator #(.LEN_W(LW), .FRAC_W(FW), .PRESC_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_len(cfg_len),
        .cfg_mode(cfg_mode), .poke_we(poke_we), .poke_data(poke_data),
        .stage_o(stage_o), .nmi_seen_o(nmi_seen_o), .irq_o(irq_o),
        .nmi_o(nmi_o), .sreset_o(sreset_o)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        #1;
        while (sb.size() > 0 && sb[0].c <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (e.c < cyc) begin
                errors++;
                $display("FAIL %s: check at cycle %0d missed (now %0d)", e.tag, e.c, cyc);
            end else if (int'(stage_o) != e.st || irq_o != e.irq || nmi_o != e.nmi ||
                         sreset_o != e.srst || nmi_seen_o != e.seen) begin
                errors++;
                $display("FAIL %s @%0d: actual stage=%0d irq=%0b nmi=%0b srst=%0b seen=%0b expected stage=%0d irq=%0b nmi=%0b srst=%0b seen=%0b",
                         e.tag, cyc, stage_o, irq_o, nmi_o, sreset_o, nmi_seen_o,
                         e.st, e.irq, e.nmi, e.srst, e.seen);
            end
        end
    end

    task automatic expect_at(int c, int st, bit i, bit n, bit s, bit sn, string tag);
        exp_t e;
        e.c = c; e.st = st; e.irq = i; e.nmi = n; e.srst = s; e.seen = sn; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wait_until(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic cfg_write(logic [LW-1:0] l, logic [1:0] m, output int e);
        @(negedge clk);
        cfg_we = 1'b1; cfg_len = l; cfg_mode = m;
        @(negedge clk);
        cfg_we = 1'b0;
        e = cyc;
    endtask

    task automatic poke(bit d, output int q);
        @(negedge clk);
        poke_we = 1'b1; poke_data = d;
        @(negedge clk);
        poke_we = 1'b0; poke_data = 1'b0;
        q = cyc;
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements): actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int e, e2, q, nx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        expect_at(cyc + 1, 0, 0, 0, 0, 0, "R1 reset idle");
        expect_at(cyc + 40, 0, 0, 0, 0, 0, "R1 stays idle while disabled");
        drain();

        // R2 R3 R4 R5: full escalation in mode 3, L=1
        cfg_write(16'd1, 2'd3, e);
        expect_at(e + T1 - 1, 0, 0, 0, 0, 0, "R2 no expiry before period");
        expect_at(e + T1,     1, 1, 0, 0, 0, "R3 first expiry irq");
        expect_at(e + 2*T1-1, 1, 1, 0, 0, 0, "R4 still irq stage");
        expect_at(e + 2*T1,   2, 1, 1, 0, 1, "R4 second expiry nmi");
        expect_at(e + 3*T1-1, 2, 1, 1, 0, 1, "R5 no reset early");
        expect_at(e + 3*T1,   0, 0, 0, 1, 1, "R5 soft reset pulse");
        expect_at(e + 3*T1+1, 0, 0, 0, 0, 1, "R5 pulse one cycle");
        expect_at(e + 4*T1,   1, 1, 0, 0, 1, "R5 counting resumes");
        wait_until(e + 4*T1 + 2);
        nx = cyc + 2;
        expect_at(nx,      0, 0, 0, 0, 0, "R8 poke clears");
        expect_at(nx + T1, 1, 1, 0, 0, 0, "R8 reload after poke");
        poke(1'b1, q);
        drain();

        // R8: poke data 0 ignored
        cfg_write(16'd1, 2'd3, e);
        wait_until(e + 20);
        poke(1'b0, q);
        expect_at(e + T1 - 1, 0, 0, 0, 0, 0, "R8 zero poke no effect before");
        expect_at(e + T1,     1, 1, 0, 0, 0, "R8 zero poke ignored");
        drain();

        // R9: poke in the expiry cycle wins
        cfg_write(16'd1, 2'd3, e);
        wait_until(e + T1 - 2);
        poke(1'b1, q);
        expect_at(e + T1,       0, 0, 0, 0, 0, "R9 poke beats expiry");
        expect_at(e + 2*T1 - 1, 0, 0, 0, 0, 0, "R9 full period after poke");
        expect_at(e + 2*T1,     1, 1, 0, 0, 0, "R9 next expiry");
        drain();

        // R6: mode 1 and mode 2 limits
        cfg_write(16'd1, 2'd1, e);
        expect_at(e + T1,   1, 1, 0, 0, 0, "R6 mode1 irq");
        expect_at(e + 2*T1, 1, 1, 0, 0, 0, "R6 mode1 holds irq");
        expect_at(e + 3*T1, 1, 1, 0, 0, 0, "R6 mode1 no reset");
        drain();
        cfg_write(16'd1, 2'd2, e);
        expect_at(e + 2*T1, 2, 1, 1, 0, 1, "R6 mode2 nmi");
        expect_at(e + 3*T1, 2, 1, 1, 0, 1, "R6 mode2 no reset");
        expect_at(e + 4*T1, 2, 1, 1, 0, 1, "R6 mode2 holds nmi");
        drain();

        // R7: disabled mode, and disabling an active stage
        cfg_write(16'd0, 2'd0, e);
        expect_at(e + 4,  0, 0, 0, 0, 0, "R7 off no expiry");
        expect_at(e + 60, 0, 0, 0, 0, 0, "R7 off stays quiet");
        drain();
        cfg_write(16'd1, 2'd3, e);
        expect_at(e + T1, 1, 1, 0, 0, 0, "R7 active before disable");
        wait_until(e + T1 + 3);
        nx = cyc + 2;
        expect_at(nx,          0, 0, 0, 0, 0, "R7 disable drops outputs");
        expect_at(nx + 3*T1+4, 0, 0, 0, 0, 0, "R7 stays off");
        cfg_write(16'd1, 2'd0, e2);
        drain();

        // R2: other lengths
        cfg_write(16'd3, 2'd3, e);
        expect_at(e + 3*T1 - 1, 0, 0, 0, 0, 0, "R2 L=3 not yet");
        expect_at(e + 3*T1,     1, 1, 0, 0, 0, "R2 L=3 expiry");
        drain();
        cfg_write(16'd0, 2'd3, e);
        expect_at(e + STEP - 1,  0, 0, 0, 0, 0, "R2 L=0 not yet");
        expect_at(e + STEP,      1, 1, 0, 0, 0, "R2 L=0 one step");
        expect_at(e + 2*STEP,    2, 1, 1, 0, 1, "R2 L=0 nmi");
        expect_at(e + 3*STEP,    0, 0, 0, 1, 1, "R2 L=0 reset pulse");
        drain();

        // R10: rewrite mid-period restarts timing
        cfg_write(16'd1, 2'd3, e);
        wait_until(e + 30);
        nx = cyc + 2;
        expect_at(e + T1,         0, 0, 0, 0, 0, "R10 old period cancelled");
        expect_at(nx + 2*T1 - 1,  0, 0, 0, 0, 0, "R10 new length not yet");
        expect_at(nx + 2*T1,      1, 1, 0, 0, 0, "R10 new length expiry");
        cfg_write(16'd2, 2'd3, e2);
        drain();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule